// File: doc/BRIEF.md
# Tagged Receive Character Queue for a Fast Serial Port

This block is the receive-side buffer of a fast serial port that runs a fixed
format of 8 data bits, no parity and 1 stop bit. A receiver front end hands it
one deserialised character at a time. Each character comes with two status
flags: one for a bad stop bit (a framing error) and one for a break condition.
The block stores the character and its flags together in a first-in first-out
queue that is 64 entries deep.

Software reads the oldest entry through a 32-bit data word. A read strobe on
that word removes the entry from the queue. The word carries an in-band
"queue was empty" flag next to the per-character tags. A driver can therefore
keep reading until the flag appears and never has to look at the occupancy
first.

A second 32-bit word reports occupancy. The low byte holds the receive count.
The next byte holds a transmit count, which a neighbouring transmit queue
supplies and this block only passes through. A character that arrives when
the queue is already full is lost, and the block signals an overrun pulse to
the interrupt logic, which sits outside this block.

Top module: `uart_rxq_top`

## Requirements
- R1: Entries leave in arrival order. In a data word taken from a non-empty queue, bits 7:0 hold the oldest stored character and bit 8 is 0.
- R2: A read strobe on an empty queue returns a data word with bit 8 set. Bits 10:9 and 31:11 are 0 and bits 7:0 are don't-care. The read removes nothing and leaves the receive count at 0.
- R3: In a data word from a non-empty queue, bit 9 repeats the framing-error flag and bit 10 repeats the break flag that arrived with that character. Bits 31:11 are 0.
- R4: In the level word, bits 7:0 hold the number of stored receive entries and bits 15:8 hold the transmit occupancy input unchanged. Bits 31:16 are 0.
- R5: The queue stores up to 64 entries, and the receive count never goes above 64.
- R6: A character offered while the count is 64 is discarded and the stored entries stay unchanged. The overrun output is high for exactly the one cycle that follows that push.
- R7: When a push and a read strobe arrive in the same cycle and the queue is neither empty nor full, both take effect and the count stays the same.
- R8: While reset (active low, synchronous) is held, the queue is emptied, the receive count becomes 0 and the overrun output goes low.
- R9: When a push and a read strobe arrive in the same cycle on an empty queue, the read reports empty as in R2 and the pushed character is stored, so the count becomes 1.
- R10: When a push and a read strobe arrive in the same cycle on a full queue, the oldest entry is removed, the new character is discarded with an overrun pulse, and the count becomes 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_char | input | 8 | The received character |
| rx_ferr | input | 1 | Framing-error flag for the offered character |
| rx_brk | input | 1 | Break flag for the offered character |
| dat_rd | input | 1 | Read strobe on the data word; removes the entry shown |
| dat_word | output | 32 | Data word: character, empty flag, framing and break tags |
| tx_level | input | 8 | Transmit occupancy from the transmit side |
| level_word | output | 32 | Occupancy word: receive count and transmit count |
| overrun | output | 1 | One-cycle pulse after a character is lost to a full queue |

## Verification
The bench builds the block with its default parameters: a depth of 64 entries
and 8-bit level fields. With a depth of 64 it can fill the queue completely,
so the overrun pulse, the read strobe on a full queue and the count saturating
at 64 all occur. The 8-bit level fields hold the full count of 64.

The random phase changes its push and read rates over the run. The count
therefore moves across its whole range, from empty to full, many times.
Directed sequences cover the rest: a read strobe on an empty queue, a push and
a read in the same cycle at both ends of the range, and a reset while the queue
holds entries.

// File: rtl/uart_rxq_pkg.sv
// Package: types shared by the receive queue modules.
// Assumes the serial character format is fixed at 8 data bits.
package uart_rxq_pkg;
    localparam int CHAR_W = 8;

    // One queued receive entry: the character plus its two status tags.
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/uart_rxq_count.sv
// Occupancy counter and overrun detector for the receive queue.
// Decides whether a push or a pop is accepted this cycle. A push is accepted
// only when the queue is not full, whether or not a pop arrives in the same
// cycle. A pop is accepted only when the queue is not empty.
// Assumes push_req and pop_req are single-cycle requests.
module uart_rxq_count #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovr_pulse
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assign is_empty = (count == '0);
    assign is_full  = (count == FULL_CNT);
    assign push_ok  = push_req && !is_full;
    assign pop_ok   = pop_req && !is_empty;

    // Track how many entries are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Flag one cycle after a push that found the queue full.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_pulse <= 1'b0;
        else        ovr_pulse <= push_req && is_full;
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R6
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(push_req) && $past(is_full));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req && !pop_req) |=> is_full && ovr_pulse);

    // R7
    both_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !is_empty && !is_full) |=> $stable(count));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !ovr_pulse);
endmodule

// File: rtl/uart_rxq_store.sv
// Storage array and read/write pointers for the receive queue.
// Writes at the write pointer and shows the entry at the read pointer without
// a register stage. It trusts the counter to qualify wr_en and rd_en, so it
// never writes into a full queue or reads from an empty one.
// The storage array has no reset. Only the pointers are reset.
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  rxq_entry_t wr_entry,
    input  logic       rd_en,
    output rxq_entry_t head
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // Pointer advance: a power-of-two depth wraps by itself; any other depth
    // wraps by comparing against the last index.
    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    // Move the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_nxt;
            if (rd_en) rd_ptr <= rd_nxt;
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/uart_rxq_top.sv
// Receive character queue for a fast 8N1 serial port.
// Takes characters with framing and break flags, queues them, and shows the
// oldest entry as a tagged 32-bit data word. A read strobe on that word
// removes the entry. Also builds a 32-bit level word that holds the receive
// count and the transmit count supplied from outside.
// Assumes dat_rd lasts one cycle for each register read.
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              dat_rd,
    output logic [31:0]       dat_word,
    input  logic [LVL_W-1:0]  tx_level,
    output logic [31:0]       level_word,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PAD_W = 32 - ENTRY_W - 1;
    localparam int LPAD  = 32 - 2 * LVL_W;

    logic             push_ok;
    logic             pop_ok;
    logic             q_empty;
    logic             q_full;
    logic [CNT_W-1:0] q_count;
    rxq_entry_t       in_entry;
    rxq_entry_t       head;
    rxq_entry_t       shown;

    assign in_entry = '{brk: rx_brk, ferr: rx_ferr, ch: rx_char};

    uart_rxq_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (rx_valid),
        .pop_req  (dat_rd),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .count    (q_count),
        .is_empty (q_empty),
        .is_full  (q_full),
        .ovr_pulse(overrun)
    );

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_entry(in_entry),
        .rd_en   (pop_ok),
        .head    (shown)
    );

    // Hide the stale tags of an empty queue; keep the character bits.
    always_comb begin
        head = shown;
        if (q_empty) begin
            head.brk  = 1'b0;
            head.ferr = 1'b0;
        end
    end

    // Data word: tags above the empty flag, character in the low byte.
    assign dat_word = {{PAD_W{1'b0}}, head.brk, head.ferr, q_empty, head.ch};

    // Level word: transmit count above the receive count.
    assign level_word = {{LPAD{1'b0}}, tx_level, LVL_W'(q_count)};

    // R2
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_word[8] == (level_word[LVL_W-1:0] == '0));

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_word[8] && dat_rd && !rx_valid) |=> dat_word[8]);

    // R9
    empty_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && dat_rd && rx_valid) |=> (level_word[LVL_W-1:0] == LVL_W'(1)));
endmodule

// File: tb/uart_rxq_top_tb.sv
`timescale 1ns/1ps
// Self-checking bench for uart_rxq_top, with a queue model kept in the bench.
module uart_rxq_top_tb;
    localparam int DEPTH = 64;
    localparam int LVL_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_ferr = 1'b0;
    logic        rx_brk = 1'b0;
    logic        dat_rd = 1'b0;
    logic [31:0] dat_word;
    logic [7:0]  tx_level = '0;
    logic [31:0] level_word;
    logic        overrun;

    int total = 0;
    int bad = 0;
    logic [10:0] model[$];
    logic exp_ovr = 1'b0;

    always #2.5 clk = ~clk;

    uart_rxq_top #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .dat_rd(dat_rd),
        .dat_word(dat_word), .tx_level(tx_level), .level_word(level_word),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data();
        if (model.size() == 0) return 32'h0000_0100;
        return {21'b0, model[0][10], model[0][9], 1'b0, model[0][7:0]};
    endfunction

    function automatic logic [31:0] exp_level();
        return {16'b0, tx_level, 8'(model.size())};
    endfunction

    // Compare outputs with the model; called away from the clock edge.
    task automatic compare();
        logic [31:0] e;
        e = exp_data();
        if (model.size() == 0)
            chk(dat_word[31:8] == e[31:8], "R2 empty word", dat_word, e);
        else
            chk(dat_word == e, "R1/R3 head word", dat_word, e);
        chk(level_word == exp_level(), "R4 level word", level_word, exp_level());
        chk(overrun == exp_ovr, "R6 overrun", {31'b0, overrun}, {31'b0, exp_ovr});
    endtask

    // One cycle: check state, drive inputs, update the model, pass the edge.
    task automatic step(input bit push, input logic [7:0] ch, input bit fe,
                        input bit bk, input bit rd);
        int sz;
        @(negedge clk);
        compare();
        rx_valid = push; rx_char = ch; rx_ferr = fe; rx_brk = bk; dat_rd = rd;
        sz = model.size();
        exp_ovr = push && (sz >= DEPTH);
        if (rd && sz > 0) void'(model.pop_front());
        if (push && sz < DEPTH) model.push_back({bk, fe, 1'b0, ch});
        @(posedge clk);
        #0.5;
        rx_valid = 1'b0; dat_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        exp_ovr = 1'b0;
    endtask

    initial begin
        #(200000 * 5.0);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R8: reset state
        chk(level_word == 32'h0, "R8 level after reset", level_word, 32'h0);
        chk(dat_word[8] == 1'b1, "R8 empty after reset", {31'b0, dat_word[8]}, 32'h1);
        chk(overrun == 1'b0, "R8 overrun after reset", {31'b0, overrun}, 32'h0);

        // R2: read on empty removes nothing
        step(0, 8'h00, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0);
        // R9: push and read together on an empty queue
        step(1, 8'hA5, 1, 0, 1);
        step(0, 8'h00, 0, 0, 0);
        chk(level_word[7:0] == 8'd1, "R9 count after push+read", level_word, 32'd1);

        // R5/R6: fill to 64, then overflow
        tx_level = 8'h3C;
        while (model.size() < DEPTH)
            step(1, 8'($urandom), 1'($urandom), 1'($urandom), 0);
        step(1, 8'hEE, 1, 1, 0);
        step(1, 8'hEF, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        chk(level_word[7:0] == 8'd64, "R5 count caps at 64", level_word, 32'd64);
        // R10: push and read together on a full queue
        step(1, 8'h77, 0, 1, 1);
        step(0, 8'h00, 0, 0, 0);
        chk(level_word[7:0] == 8'd63, "R10 count after full push+read", level_word, 32'd63);
        // R7: push and read together in the middle
        step(1, 8'h11, 0, 0, 1);
        step(1, 8'h22, 1, 0, 1);
        step(0, 8'h00, 0, 0, 0);
        chk(level_word[7:0] == 8'd63, "R7 count steady", level_word, 32'd63);

        // Drain completely, reading past empty (R1, R3, R2)
        while (model.size() > 0) step(0, 8'h00, 0, 0, 1);
        step(0, 8'h00, 0, 0, 1);

        // Random phases with changing push and read rates
        for (int ph = 0; ph < 8; ph++) begin
            int pp;
            int rp;
            pp = (ph % 2 == 0) ? 80 : 25;
            rp = (ph % 2 == 0) ? 25 : 80;
            for (int i = 0; i < 600; i++) begin
                if (i % 97 == 0) tx_level = 8'($urandom);
                step(($urandom % 100) < pp, 8'($urandom), 1'($urandom),
                     1'($urandom), ($urandom % 100) < rp);
            end
        end

        // R8: reset with entries stored
        while (model.size() < 10) step(1, 8'($urandom), 0, 0, 0);
        do_reset();
        chk(level_word[7:0] == 8'd0, "R8 reset empties queue", level_word, 32'd0);
        chk(dat_word[8] == 1'b1, "R8 empty flag after reset", dat_word, 32'h100);
        step(0, 8'h00, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule